// File: doc/BRIEF.md
# Real-Time Clock Update Cycle Sequencer

This block paces the once-per-second update of a real-time clock. A seconds tick from the divider chain starts a sequence that is timed entirely in enables of a 32.768 kHz timebase. First a busy status flag goes high. A fixed number of enables later, a single-cycle advance strobe tells the time counters to step. After a longer fixed window, a single-cycle completion strobe marks the end of the update and the busy flag drops.

Software reads the busy flag to know when the time registers must not be trusted. The flag rises several timebase periods before the counters move, and it stays high for the whole update window. A set-mode input lets software load a new time. While it is high, new ticks are dropped and no update starts. A cycle already running when set mode rises still runs to its end. When set mode is released, nothing starts until the next regular tick.

With the default timing, the lead is 8 enables (about 244 us) and the update window is 65 enables (about 1.98 ms). The flag is therefore high for 73 enables (about 2.23 ms).

Top module: `rtc_update_seq`

## Requirements
- R1: A tick is accepted only on a clock edge where `tick_1hz`=1, `ce_32k`=1, `set_mode`=0 and `uip`=0. `uip` reads 1 in the clock cycle that follows that edge.
- R2: Once raised, `uip` stays 1 through LEAD_CYC+UPD_CYC (default 73) further `ce_32k` enables. It reads 0 in the cycle after the last of them.
- R3: `adv_strobe` is 1 for exactly one clock cycle. That cycle is the one right after the LEAD_CYC-th (default 8th) enable that follows the accepted tick. `adv_strobe` is 0 at all other times.
- R4: `upd_done` is 1 for exactly one clock cycle. That cycle is the one right after the (LEAD_CYC+UPD_CYC)-th enable, and it is the same cycle in which `uip` first reads 0 again.
- R5: The outputs change only after edges where `ce_32k`=1. A tick with `ce_32k`=0 has no effect.
- R6: A tick that arrives while `uip`=1 is dropped. The timing of the running cycle is unchanged, and no second cycle follows it.
- R7: A tick that arrives while `set_mode`=1 is dropped. No update cycle comes from it, either at once or later.
- R8: If `set_mode` rises while a cycle runs, that cycle still issues its advance strobe and completion strobe on schedule.
- R9: When `set_mode` falls, no cycle starts by itself. The next accepted tick starts a normal cycle.
- R10: While `rst_n`=0, and just after reset, `uip`, `adv_strobe` and `upd_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | Once-per-second tick from the divider chain |
| ce_32k | input | 1 | One-cycle enable at the 32.768 kHz timebase rate |
| set_mode | input | 1 | 1 = software is loading time; new updates are inhibited |
| uip | output | 1 | Update-in-progress status flag |
| adv_strobe | output | 1 | One-cycle strobe telling the time counters to advance |
| upd_done | output | 1 | One-cycle strobe marking the end of the update window |

## Verification
Full cycles are run with the enable spaced 1, 2, 3 and 4 clocks apart. Spacing 1 shows whether the strobes last one clock rather than one enable period. Wider spacing shows whether the block counts enables rather than clocks. Further runs inject ticks without an enable, ticks during the lead window, ticks mid-update and ticks on the completion edge, which show whether a busy cycle can be restarted or stretched. Set mode is raised before a tick, raised mid-cycle and released with no tick following, which separates dropping a tick from aborting a running cycle and from starting one on release.

// File: rtl/rtc_seq_pkg.sv
`timescale 1ns/1ps
package rtc_seq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_LEAD   = 2'd1,
    SEQ_UPDATE = 2'd2
  } seq_state_e;

  // True when a window counter sits on its final enable of a window of len enables
  function automatic logic window_last(input int unsigned cnt, input int unsigned len);
    return (cnt + 1) == len;
  endfunction

  // Number of enables for which the busy flag is held
  function automatic int unsigned busy_span(input int unsigned lead, input int unsigned upd);
    return lead + upd;
  endfunction

  // Counter width that can hold values 0..n
  function automatic int unsigned count_width(input int unsigned n);
    int unsigned w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

endpackage

// File: rtl/rtc_tick_gate.sv
`timescale 1ns/1ps
module rtc_tick_gate (
  input  logic tick_1hz,
  input  logic ce_32k,
  input  logic set_mode,
  input  logic idle,
  output logic accept
);
  // A tick counts only on a timebase enable, outside set mode, with no cycle running
  always_comb begin
    accept = tick_1hz & ce_32k & ~set_mode & idle;
  end
endmodule

// File: rtl/rtc_phase_timer.sv
`timescale 1ns/1ps
module rtc_phase_timer #(
  parameter int unsigned CW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_32k,
  input  logic          run,
  input  logic          clr,
  input  logic [CW-1:0] limit,
  output logic          last
);
  import rtc_seq_pkg::*;

  logic [CW-1:0] cnt_q;

  always_comb begin
    last = run & ce_32k & window_last(32'(cnt_q), 32'(limit));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && ce_32k) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_seq_ctrl.sv
`timescale 1ns/1ps
module rtc_seq_ctrl
  import rtc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       phase_last,
  output seq_state_e state,
  output logic       adv_q,
  output logic       done_q
);
  seq_state_e state_d;
  logic       adv_d;
  logic       done_d;

  always_comb begin
    state_d = state;
    adv_d   = 1'b0;
    done_d  = 1'b0;
    unique case (state)
      SEQ_IDLE: begin
        if (accept) state_d = SEQ_LEAD;
      end
      SEQ_LEAD: begin
        if (phase_last) begin
          state_d = SEQ_UPDATE;
          adv_d   = 1'b1;
        end
      end
      SEQ_UPDATE: begin
        if (phase_last) begin
          state_d = SEQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      adv_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      state  <= state_d;
      adv_q  <= adv_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/rtc_update_seq.sv
`timescale 1ns/1ps
module rtc_update_seq #(
  parameter int unsigned LEAD_CYC = 8,
  parameter int unsigned UPD_CYC  = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_1hz,
  input  logic ce_32k,
  input  logic set_mode,
  output logic uip,
  output logic adv_strobe,
  output logic upd_done
);
  import rtc_seq_pkg::*;

  localparam int unsigned MAX_WIN = (LEAD_CYC > UPD_CYC) ? LEAD_CYC : UPD_CYC;
  localparam int unsigned CW      = count_width(MAX_WIN);

  seq_state_e    state;
  logic          tick_accept;
  logic          phase_last;
  logic          timer_run;
  logic          timer_clr;
  logic [CW-1:0] win_limit;
  logic          adv_q;
  logic          done_q;

  rtc_tick_gate u_gate (
    .tick_1hz (tick_1hz),
    .ce_32k   (ce_32k),
    .set_mode (set_mode),
    .idle     (state == SEQ_IDLE),
    .accept   (tick_accept)
  );

  always_comb begin
    timer_run = (state != SEQ_IDLE);
    timer_clr = tick_accept | phase_last;
    win_limit = (state == SEQ_LEAD) ? CW'(LEAD_CYC) : CW'(UPD_CYC);
  end

  rtc_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_32k (ce_32k),
    .run    (timer_run),
    .clr    (timer_clr),
    .limit  (win_limit),
    .last   (phase_last)
  );

  rtc_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (tick_accept),
    .phase_last (phase_last),
    .state      (state),
    .adv_q      (adv_q),
    .done_q     (done_q)
  );

  assign uip        = (state != SEQ_IDLE);
  assign adv_strobe = adv_q;
  assign upd_done   = done_q;
endmodule

// File: rtl/rtc_update_seq_chk.sv
`timescale 1ns/1ps
module rtc_update_seq_chk #(
  parameter int unsigned LEAD_CYC = 8,
  parameter int unsigned UPD_CYC  = 65
) (
  input logic clk,
  input logic rst_n,
  input logic tick_1hz,
  input logic ce_32k,
  input logic set_mode,
  input logic uip,
  input logic adv_strobe,
  input logic upd_done,
  input logic tick_accept
);
  import rtc_seq_pkg::*;

  localparam int unsigned SPAN = busy_span(LEAD_CYC, UPD_CYC);
  localparam int unsigned SW   = count_width(SPAN) + 1;

  logic [SW-1:0] seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_q <= '0;
    else if (tick_accept) seen_q <= '0;
    else if (uip && ce_32k) seen_q <= seen_q + 1'b1;
  end

  // R1
  uip_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uip) |-> $past(tick_1hz && ce_32k && !set_mode));

  // R2
  uip_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> (seen_q == SW'(SPAN)));

  // R3
  adv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_strobe |=> !adv_strobe);

  // R3
  adv_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_strobe |-> (uip && seen_q == SW'(LEAD_CYC)));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R4
  done_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uip) |-> upd_done);

  // R5
  ce_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(uip) |-> $past(ce_32k));

  // R7
  set_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mode && !uip) |=> !uip);
endmodule

bind rtc_update_seq rtc_update_seq_chk #(
  .LEAD_CYC (LEAD_CYC),
  .UPD_CYC  (UPD_CYC)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_1hz    (tick_1hz),
  .ce_32k      (ce_32k),
  .set_mode    (set_mode),
  .uip         (uip),
  .adv_strobe  (adv_strobe),
  .upd_done    (upd_done),
  .tick_accept (tick_accept)
);

// File: tb/test_rtc_update_seq.sv
`timescale 1ns/1ps
module test_rtc_update_seq;
  localparam int LEAD = 8;
  localparam int UPD  = 65;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 1'b0;
  logic ce_32k = 1'b0;
  logic set_mode = 1'b0;
  logic uip, adv_strobe, upd_done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  // reference state
  bit m_busy = 1'b0;
  int m_cnt  = 0;

  always #4 clk = ~clk;

  rtc_update_seq #(.LEAD_CYC(LEAD), .UPD_CYC(UPD)) i_rtc_update_seq (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .ce_32k(ce_32k),
    .set_mode(set_mode), .uip(uip), .adv_strobe(adv_strobe), .upd_done(upd_done)
  );

  task automatic check(input string tag, input string sig, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, sig, act, exp, $time);
    end
  endtask

  // One clock: drive inputs, clock, then compare against the reference
  task automatic step(input bit ce, input bit tk, input bit sm, input string tag);
    bit adv_e, done_e;
    @(negedge clk);
    ce_32k = ce; tick_1hz = tk; set_mode = sm;
    @(posedge clk);
    #1;
    adv_e = 1'b0; done_e = 1'b0;
    if (ce) begin
      if (!m_busy) begin
        if (tk && !sm) begin m_busy = 1'b1; m_cnt = 0; end
      end else begin
        m_cnt++;
        if (m_cnt == LEAD) adv_e = 1'b1;
        if (m_cnt == LEAD + UPD) begin done_e = 1'b1; m_busy = 1'b0; end
      end
    end
    check(tag, "uip(R2)", uip, m_busy);
    check(tag, "adv_strobe(R3)", adv_strobe, adv_e);
    check(tag, "upd_done(R4)", upd_done, done_e);
  endtask

  // period-1 idle clocks then one enable clock
  task automatic en_step(input int period, input bit tk, input bit sm, input string tag);
    for (int i = 0; i < period - 1; i++) step(1'b0, 1'b0, sm, tag);
    step(1'b1, tk, sm, tag);
  endtask

  initial begin
    #1600000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    // R10: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R10 in reset", "uip", uip, 1'b0);
    check("R10 in reset", "adv_strobe", adv_strobe, 1'b0);
    check("R10 in reset", "upd_done", upd_done, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 1'b0, 1'b0, "R10 after reset");

    // R1 R2 R3 R4: full cycles with several enable spacings
    for (int p = 1; p <= 4; p++) begin
      en_step(p, 1'b1, 1'b0, $sformatf("R1/R2/R3/R4 period %0d", p));
      for (int e = 0; e < LEAD + UPD + 4; e++)
        en_step(p, 1'b0, 1'b0, $sformatf("R1/R2/R3/R4 period %0d", p));
    end

    // R5: ticks without an enable are ignored
    for (int i = 0; i < 12; i++) step(1'b0, 1'b1, 1'b0, "R5 tick no enable");
    en_step(2, 1'b0, 1'b0, "R5 idle enable");

    // R6: ticks inside the lead window, mid-update and on the completion edge
    en_step(2, 1'b1, 1'b0, "R6 start");
    for (int e = 1; e <= LEAD + UPD + 6; e++) begin
      bit t = (e == 3) || (e == LEAD) || (e == 40) || (e == LEAD + UPD);
      en_step(2, t, 1'b0, "R6 busy tick");
    end

    // R7: tick during set mode is dropped
    en_step(1, 1'b0, 1'b1, "R7 enter set");
    en_step(1, 1'b1, 1'b1, "R7 tick in set");
    for (int e = 0; e < LEAD + UPD + 4; e++) en_step(1, 1'b0, 1'b1, "R7 stay idle");

    // R8: set mode raised mid-cycle, cycle still completes
    en_step(1, 1'b0, 1'b0, "R8 leave set");
    en_step(3, 1'b1, 1'b0, "R8 start");
    for (int e = 1; e <= LEAD + UPD + 4; e++)
      en_step(3, 1'b0, (e >= 5), "R8 set mid cycle");
    en_step(3, 1'b1, 1'b1, "R7 tick while set held");
    for (int e = 0; e < 10; e++) en_step(3, 1'b0, 1'b1, "R7 stay idle");

    // R9: releasing set mode does not start a cycle; next tick does
    for (int e = 0; e < 20; e++) en_step(2, 1'b0, 1'b0, "R9 released no tick");
    en_step(2, 1'b1, 1'b0, "R9 next tick");
    for (int e = 0; e < LEAD + UPD + 4; e++) en_step(2, 1'b0, 1'b0, "R9 cycle");

    // back-to-back: tick on the enable right after completion
    en_step(1, 1'b1, 1'b0, "R1 again");
    for (int e = 1; e <= LEAD + UPD; e++) en_step(1, 1'b0, 1'b0, "R1 again");
    en_step(1, 1'b1, 1'b0, "R1 right after done");
    for (int e = 0; e < LEAD + UPD + 3; e++) en_step(1, 1'b0, 1'b0, "R1 right after done");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule